// File: doc/BRIEF.md
# Synchronization-Slot Word Generator

This block produces the 8-bit word that goes into the synchronization channel of every frame in a 16-frame multiframe. It tracks which frame is current. Odd frames carry a fixed alignment pattern. Even frames carry a message word, which is assembled from two alarm flags and a four-bit service field. The most significant bit of each word is a CRC-4 check bit. That bit comes from an external checksum engine, or is forced to one when checking is switched off.

A frame strobe marks the start of each new frame. On that strobe the counter advances, the word for the new frame is latched, and the serial pointer returns to the first bit. The word is available in parallel, and also as a serial stream that sends the most significant bit first and moves one bit per bit-enable pulse. A one-cycle flag marks the start of each multiframe. Receiver alignment search and the checksum arithmetic are handled outside this block.

Top module: `sync_slot_word_gen`

## Requirements
- R1: After reset the current frame is frame 1, `slot_word` is 8'h9B (check bit 1 followed by the alignment pattern), `slot_serial` is 1 and `mf_start` is 0.
- R2: Each `frame_strobe` advances the frame number by one in the range 1 to 16. Between strobes the frame number does not change, so frame kinds alternate strictly: odd, even, odd, and so on.
- R3: A strobe issued while the frame number is 16 wraps it to 1. `mf_start` is 1 in the single cycle after that strobe edge and 0 in every other cycle.
- R4: In odd frames, bits 6..0 of `slot_word` equal 7'b0011011.
- R5: In even frames, bit 6 is 1, bit 5 is `alarm_d`, bit 4 is `alarm_n` and bits 3..0 are `service_bits`. All of these are sampled on the strobe that starts the frame.
- R6: Changes to `alarm_d`, `alarm_n`, `service_bits`, `crc_bit` or `crc_off` between strobes leave `slot_word` and the serial stream unchanged.
- R7: Bit 7 of every word latched on a strobe equals `crc_bit` sampled on that strobe when `crc_off` is 0, and equals 1 when `crc_off` is 1.
- R8: After a strobe, `slot_serial` shows bit 7. Each `bit_en` pulse moves it to the next lower bit. Once it reaches bit 0, further pulses keep it on bit 0.
- R9: When `frame_strobe` and `bit_en` are high in the same cycle, the strobe takes priority and the serial pointer restarts at bit 7.
- R10: `slot_word` and `mf_start` change only on the clock edge where `frame_strobe` is sampled high. They are first visible in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | Starts the next frame |
| bit_en | input | 1 | Moves the serial output to the next bit |
| crc_bit | input | 1 | Check bit for the frame being started |
| crc_off | input | 1 | Forces the check bit to 1 |
| alarm_d | input | 1 | First alarm flag for message words |
| alarm_n | input | 1 | Second alarm flag for message words |
| service_bits | input | 4 | Service field for message words |
| slot_word | output | 8 | Parallel word of the current frame |
| slot_serial | output | 1 | Serial bit of the current word, most significant bit first |
| mf_start | output | 1 | One-cycle flag at the start of frame 1 |

## Verification
The hardest case to reach is the wrap from frame 16 to frame 1, and the check that the multiframe flag appears only there. Getting there takes a full 16 strobes, and the case only means something if the alternation has stayed in step the whole way. The stimulus therefore runs three complete multiframes. Every strobe carries a different combination of check bit, disable input and message fields. Inputs are flipped mid-frame, the serial pointer is driven past its last bit, and strobe and bit-enable are made to collide on chosen frames.

// File: rtl/sync_slot_pkg.sv
package sync_slot_pkg;

   typedef enum logic {
      KIND_ALIGN   = 1'b0,
      KIND_MESSAGE = 1'b1
   } frame_kind_e;

   // Odd frame numbers carry the alignment pattern, even ones the message word.
   function automatic frame_kind_e kind_of(input logic lsb);
      return lsb ? KIND_ALIGN : KIND_MESSAGE;
   endfunction

endpackage

// File: rtl/sync_slot_frame_ctr.sv
module sync_slot_frame_ctr
   import sync_slot_pkg::*;
#(
   parameter int FRAMES = 16,
   localparam int CNT_W = $clog2(FRAMES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output frame_kind_e      cur_kind,
   output frame_kind_e      nxt_kind,
   output logic             wrap_pulse
);

   localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAMES);

   if (FRAMES < 2 || (FRAMES % 2) != 0) begin : g_bad_frames
      $error("FRAMES must be even and at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             at_last;
   logic             wrap_q;

   assign at_last = (cnt_q == LAST);
   assign cnt_nxt = at_last ? FIRST : cnt_q + FIRST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= FIRST;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= adv && at_last;
         if (adv) begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   assign cnt        = cnt_q;
   assign cur_kind   = kind_of(cnt_q[0]);
   assign nxt_kind   = kind_of(cnt_nxt[0]);
   assign wrap_pulse = wrap_q;

   a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= FIRST) && (cnt_q <= LAST));
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !at_last) |=> (cnt_q == $past(cnt_q) + FIRST));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt_q));
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && at_last) |=> (cnt_q == FIRST) && wrap_q);
   a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);

endmodule

// File: rtl/sync_slot_word_build.sv
module sync_slot_word_build
   import sync_slot_pkg::*;
#(
   parameter int                  WORD_W     = 8,
   parameter int                  SVC_W      = 4,
   parameter logic [WORD_W-2:0]   ALIGN_BITS = 7'b0011011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  frame_kind_e       kind,
   input  logic              x_bit,
   input  logic              flag_d,
   input  logic              flag_n,
   input  logic [SVC_W-1:0]  svc,
   output logic [WORD_W-1:0] word_q
);

   if (WORD_W != SVC_W + 4) begin : g_bad_width
      $error("WORD_W must equal SVC_W + 4");
   end

   logic [WORD_W-1:0] word_r;
   logic [WORD_W-2:0] body;

   always_comb begin
      if (kind == KIND_MESSAGE) begin
         body = {1'b1, flag_d, flag_n, svc};
      end else begin
         body = ALIGN_BITS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_r <= {1'b1, ALIGN_BITS};
      end else if (load) begin
         word_r <= {x_bit, body};
      end
   end

   assign word_q = word_r;

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(word_r));
   a_r7_lead: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (word_r[WORD_W-1] == $past(x_bit)));

endmodule

// File: rtl/sync_slot_serializer.sv
module sync_slot_serializer #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic [WORD_W-1:0] word,
   output logic              ser_bit
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (restart) begin
         idx_q <= '0;
      end else if (step && (idx_q != IDX_LAST)) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   if (MSB_FIRST) begin : g_msb
      assign pos = IDX_LAST - idx_q;
   end else begin : g_lsb
      assign pos = idx_q;
   end

   assign ser_bit = word[pos];

   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idx_q == '0));
   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && (idx_q == IDX_LAST)) |=> (idx_q == IDX_LAST));
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !step) |=> $stable(idx_q));

endmodule

// File: rtl/sync_slot_word_gen.sv
module sync_slot_word_gen
   import sync_slot_pkg::*;
#(
   parameter int                FRAMES     = 16,
   parameter int                SVC_W      = 4,
   parameter bit                USE_CRC    = 1'b1,
   localparam int               WORD_W     = SVC_W + 4,
   parameter logic [WORD_W-2:0] ALIGN_BITS = 7'b0011011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_strobe,
   input  logic              bit_en,
   input  logic              crc_bit,
   input  logic              crc_off,
   input  logic              alarm_d,
   input  logic              alarm_n,
   input  logic [SVC_W-1:0]  service_bits,
   output logic [WORD_W-1:0] slot_word,
   output logic              slot_serial,
   output logic              mf_start
);

   localparam int CNT_W = $clog2(FRAMES + 1);

   logic [CNT_W-1:0] cnt;
   frame_kind_e      cur_kind;
   frame_kind_e      nxt_kind;
   logic             x_sel;

   if (USE_CRC) begin : g_crc
      assign x_sel = crc_off ? 1'b1 : crc_bit;
   end else begin : g_nocrc
      assign x_sel = 1'b1;
   end

   sync_slot_frame_ctr #(.FRAMES(FRAMES)) i_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (frame_strobe),
      .cnt        (cnt),
      .cur_kind   (cur_kind),
      .nxt_kind   (nxt_kind),
      .wrap_pulse (mf_start)
   );

   sync_slot_word_build #(
      .WORD_W     (WORD_W),
      .SVC_W      (SVC_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) i_build (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (frame_strobe),
      .kind   (nxt_kind),
      .x_bit  (x_sel),
      .flag_d (alarm_d),
      .flag_n (alarm_n),
      .svc    (service_bits),
      .word_q (slot_word)
   );

   sync_slot_serializer #(.WORD_W(WORD_W), .MSB_FIRST(1'b1)) i_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (frame_strobe),
      .step    (bit_en),
      .word    (slot_word),
      .ser_bit (slot_serial)
   );

   // Cross-checks between the counter state and the latched word.
   a_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_kind == KIND_ALIGN) |-> (slot_word[WORD_W-2:0] == ALIGN_BITS));
   a_r5_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_kind == KIND_MESSAGE) |-> slot_word[WORD_W-2]);
   a_r7_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_strobe && crc_off) |=> slot_word[WORD_W-1]);
   a_r8_first: assert property (@(posedge clk) disable iff (!rst_n)
      frame_strobe |=> (slot_serial == slot_word[WORD_W-1]));
   a_r10_frame1: assert property (@(posedge clk) disable iff (!rst_n)
      mf_start |-> (cnt == CNT_W'(1)));

endmodule

// File: tb/test_sync_slot_word_gen.sv
`timescale 1ns/1ps
module test_sync_slot_word_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_strobe = 1'b0;
   logic       bit_en = 1'b0;
   logic       crc_bit = 1'b0;
   logic       crc_off = 1'b0;
   logic       alarm_d = 1'b0;
   logic       alarm_n = 1'b0;
   logic [3:0] service_bits = 4'h0;
   logic [7:0] slot_word;
   logic       slot_serial;
   logic       mf_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int frame_no = 1;

   always #2.5 clk = ~clk;

   sync_slot_word_gen i_sync_slot_word_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .bit_en       (bit_en),
      .crc_bit      (crc_bit),
      .crc_off      (crc_off),
      .alarm_d      (alarm_d),
      .alarm_n      (alarm_n),
      .service_bits (service_bits),
      .slot_word    (slot_word),
      .slot_serial  (slot_serial),
      .mf_start     (mf_start)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input int k);
      logic [7:0] exp;
      int         nf;
      bit         x;
      bit         collide;
      nf      = (frame_no == 16) ? 1 : frame_no + 1;
      collide = (k % 4) == 3;
      @(negedge clk);
      crc_bit      = k[0] ^ k[2];
      crc_off      = (k % 5) == 0;
      alarm_d      = k[1];
      alarm_n      = k[3] ^ k[0];
      service_bits = 4'(k * 3 + 1);
      frame_strobe = 1'b1;
      bit_en       = collide;
      x            = crc_off ? 1'b1 : crc_bit;
      if (nf % 2 == 1) exp = {x, 7'b0011011};
      else             exp = {x, 1'b1, alarm_d, alarm_n, service_bits};
      @(negedge clk);
      frame_strobe = 1'b0;
      bit_en       = 1'b0;
      frame_no     = nf;
      // R2 R4 R5 R7 R10: word of the new frame visible one cycle after the strobe
      check(slot_word == exp, (nf % 2 == 1) ? "R4/R7 align word" : "R5/R7 message word", slot_word, exp);
      check(slot_word[6] == ((nf % 2 == 1) ? 1'b0 : 1'b1), "R2 kind alternation", {7'd0, slot_word[6]}, {7'd0, (nf % 2 == 0)});
      check(mf_start == (nf == 1), "R3 multiframe flag", {7'd0, mf_start}, {7'd0, nf == 1});
      // R8 R9: pointer restarts at bit 7 even when bit_en collided with the strobe
      check(slot_serial == exp[7], collide ? "R9 strobe priority" : "R8 first serial bit",
            {7'd0, slot_serial}, {7'd0, exp[7]});
      // R6: flip every sampled input mid-frame
      crc_bit      = ~crc_bit;
      crc_off      = ~crc_off;
      alarm_d      = ~alarm_d;
      alarm_n      = ~alarm_n;
      service_bits = ~service_bits;
      @(negedge clk);
      check(slot_word == exp, "R6 inputs ignored between strobes", slot_word, exp);
      check(mf_start == 1'b0, "R3 flag lasts one cycle", {7'd0, mf_start}, 8'd0);
      check(slot_serial == exp[7], "R6 serial unchanged without bit_en", {7'd0, slot_serial}, {7'd0, exp[7]});
      for (int b = 1; b <= 9; b++) begin
         bit_en = 1'b1;
         @(negedge clk);
         bit_en = 1'b0;
         check(slot_serial == exp[7 - ((b > 7) ? 7 : b)], (b > 7) ? "R8 hold on last bit" : "R8 serial step",
               {7'd0, slot_serial}, {7'd0, exp[7 - ((b > 7) ? 7 : b)]});
      end
      check(slot_word == exp, "R10 word stable without strobe", slot_word, exp);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(slot_word == 8'h9B, "R1 reset word", slot_word, 8'h9B);
      check(slot_serial == 1'b1, "R1 reset serial", {7'd0, slot_serial}, 8'd1);
      check(mf_start == 1'b0, "R1 reset flag", {7'd0, mf_start}, 8'd0);
      for (int k = 0; k < 48; k++) begin
         run_frame(k);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule